// File: doc/BRIEF.md
# Interrupt Pin Service Engine

This block keeps the request state of every interrupt input line and decides when a line is offered to the processor-side interrupt controllers. Each pin has its own table entry: mask, trigger mode (edge or level), vector, destination, delivery mode and logical/physical destination flag. The engine watches the line levels. A pending service is turned into a delivery request only if the entry allows it. The engine then waits for the far side to accept, and the accept comes with the number of targets that took the interrupt.

Level-triggered pins are throttled by a per-pin remote-IRR bit. An accepted level delivery sets the bit, and an end-of-interrupt (EOI) for the pin's vector clears it and redelivers the pin if its line is still active. Every immediate redelivery on EOI is counted per pin. At the storm threshold the count clears and the redelivery is deferred: a shared timer runs for a fixed number of cycles and then services every level pin that is still requesting. A rewrite strobe from the register block tells the engine that an entry was changed.

The service controller has two states. In `SVC_IDLE` it picks the lowest pending pin. That pin is either refused and dropped (IDLE stays IDLE) or latched, which is the transition *take* to `SVC_OFFER`. In `SVC_OFFER` the request is held until `dlv_accept`, which is the transition *accept* back to `SVC_IDLE`. The deferral timer also has two states. In `DLY_IDLE` a storm is the transition *arm* to `DLY_COUNT`. In `DLY_COUNT` the timer counts down. At zero it takes the transition *fire* back to `DLY_IDLE`, or it re-arms if another storm arrives in that same cycle.

Top module: `pinsvc_engine`

## Requirements
- R1: After reset no request is offered, and every IRR and remote-IRR bit reads 0.
- R2: A pin's IRR follows its line one cycle later. A 0-to-1 change of IRR queues one service attempt. A line held high queues nothing more, so a held edge pin is coalesced. When a level pin's line falls, its IRR clears and any queued attempt for it is dropped.
- R3: A service attempt is refused and discarded, with no request, when the entry is masked or when the entry is level-triggered with remote IRR set.
- R4: A request carries the entry's vector, destination, delivery mode, logical flag and trigger mode (1 = level) as seen when the pin was picked. These fields and `dlv_valid` stay unchanged until `dlv_accept`.
- R5: A level request accepted with a nonzero target count sets that pin's remote IRR. A zero count, or an edge request, leaves it at 0.
- R6: When several pins are pending, the lowest-numbered pin is served first.
- R7: A level-mode, non-directed EOI acts on every pin whose vector equals the EOI vector. It clears remote IRR on each such pin and queues an immediate redelivery for each one that is unmasked with IRR set.
- R8: An EOI that is marked directed, or that carries edge mode (`eoi_level` = 0), changes no remote-IRR bit and no counter.
- R9: Each immediate EOI redelivery increments the pin's counter. The EOI that would make the counter reach STORM_LIMIT instead clears it and arms the deferral timer, with no immediate redelivery. An EOI that finds the pin masked or its IRR clear resets the counter to 0.
- R10: DEFER_CYCLES cycles after arming, every level pin with IRR set and remote IRR clear gets a service attempt.
- R11: A rewrite strobe on a level entry whose IRR is set queues a service attempt. A rewrite strobe on an edge entry clears its remote IRR.
- R12: When an accept and an EOI for the offered pin's vector land in the same cycle, the accept wins and remote IRR ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_line | input | NUM_PINS | Combined level of each interrupt line |
| cfg_mask | input | NUM_PINS | Entry mask, 1 = masked |
| cfg_level | input | NUM_PINS | Entry trigger mode, 1 = level, 0 = edge |
| cfg_logical | input | NUM_PINS | Entry destination mode flag |
| cfg_dmode | input | 3*NUM_PINS | Entry delivery mode, 3 bits per pin |
| cfg_vector | input | VEC_W*NUM_PINS | Entry vector, VEC_W bits per pin |
| cfg_dest | input | DEST_W*NUM_PINS | Entry destination, DEST_W bits per pin |
| cfg_rewrite | input | NUM_PINS | One-cycle strobe: entry was rewritten |
| eoi_valid | input | 1 | EOI broadcast present |
| eoi_vector | input | VEC_W | Vector being retired |
| eoi_level | input | 1 | EOI trigger mode, 1 = level |
| eoi_directed | input | 1 | EOI handled by a directed path; ignore remote IRR |
| dlv_valid | output | 1 | Delivery request offered |
| dlv_pin | output | PIN_W | Pin of the offered request |
| dlv_vector | output | VEC_W | Vector of the offered request |
| dlv_dest | output | DEST_W | Destination of the offered request |
| dlv_dmode | output | 3 | Delivery mode of the offered request |
| dlv_logical | output | 1 | Destination mode flag of the offered request |
| dlv_level | output | 1 | Trigger mode of the offered request |
| dlv_accept | input | 1 | Request taken by the controller side |
| dlv_count | input | TGT_W | Number of targets that took it, valid with accept |
| irr | output | NUM_PINS | Per-pin request state |
| rirr | output | NUM_PINS | Per-pin remote-IRR state |

## Verification
The accept of an offered level request and an EOI naming that request's vector can arrive in the same cycle. The first one sets remote IRR and the second one clears it. The bench raises a level line and counts edges so that the EOI is driven on the exact falling edge where the monitor raises `dlv_accept`. It then requires remote IRR to read 1 and requires no second request. The redelivery queued by that EOI must be refused. A second overlap comes from a storm: the deferral timer firing on a pin whose delivery was accepted with zero targets. The bench checks that both deferred pins come out in ascending order and that none appears before the delay has passed.

// File: rtl/pinsvc_pkg.sv
package pinsvc_pkg;

    localparam int DMODE_W = 3;

    typedef enum logic [0:0] {
        SVC_IDLE  = 1'b0,
        SVC_OFFER = 1'b1
    } svc_state_e;

    typedef enum logic [0:0] {
        DLY_IDLE  = 1'b0,
        DLY_COUNT = 1'b1
    } dly_state_e;

endpackage

// File: rtl/pinsvc_pin.sv
module pinsvc_pin #(
    parameter int VEC_W       = 8,
    parameter int STORM_LIMIT = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line,
    input  logic             is_level,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             eoi_level,
    input  logic             eoi_directed,
    input  logic             rewrite,
    input  logic             defer_fire,
    input  logic             grant,
    input  logic             accept_set,
    output logic             irr,
    output logic             rirr,
    output logic             pend,
    output logic             storm
);

    localparam int CNT_W = $clog2(STORM_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STORM_LIMIT - 1);

    logic             irr_q;
    logic             rirr_q;
    logic             pend_q;
    logic [CNT_W-1:0] eoi_cnt_q;

    logic rise, fall, eoi_hit, live, redeliver, pend_set, pend_drop;

    always_comb begin
        rise      = line & ~irr_q;
        fall      = ~line & irr_q;
        eoi_hit   = eoi_valid && (vector == eoi_vector) && eoi_level && !eoi_directed;
        live      = !masked && irr_q;
        storm     = eoi_hit && live && (eoi_cnt_q == LAST);
        redeliver = eoi_hit && live && !storm;
        pend_set  = rise | redeliver
                  | (rewrite & is_level & irr_q)
                  | (defer_fire & is_level & irr_q & ~rirr_q);
        pend_drop = grant | (is_level & fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irr_q     <= 1'b0;
            rirr_q    <= 1'b0;
            pend_q    <= 1'b0;
            eoi_cnt_q <= '0;
        end else begin
            irr_q  <= line;
            pend_q <= pend_set | (pend_q & ~pend_drop);

            if (accept_set)
                rirr_q <= 1'b1;
            else if (eoi_hit)
                rirr_q <= 1'b0;
            else if (rewrite && !is_level)
                rirr_q <= 1'b0;

            if (eoi_hit) begin
                if (!live || storm)
                    eoi_cnt_q <= '0;
                else
                    eoi_cnt_q <= eoi_cnt_q + 1'b1;
            end
        end
    end

    assign irr  = irr_q;
    assign rirr = rirr_q;
    assign pend = pend_q;

endmodule

// File: rtl/pinsvc_defer.sv
module pinsvc_defer
    import pinsvc_pkg::*;
#(
    parameter int DEFER_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic fire
);

    localparam int TMR_W = $clog2(DEFER_CYCLES + 1);
    localparam logic [TMR_W-1:0] LOAD = TMR_W'(DEFER_CYCLES - 1);

    dly_state_e       st_q;
    logic [TMR_W-1:0] cnt_q;

    assign fire = (st_q == DLY_COUNT) && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DLY_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                DLY_IDLE: begin
                    if (start) begin
                        st_q  <= DLY_COUNT;
                        cnt_q <= LOAD;
                    end
                end
                DLY_COUNT: begin
                    if (cnt_q == '0) begin
                        if (start) begin
                            cnt_q <= LOAD;
                        end else begin
                            st_q <= DLY_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= DLY_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pinsvc_pick.sv
module pinsvc_pick #(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = 5
) (
    input  logic [NUM_PINS-1:0] req,
    output logic [NUM_PINS-1:0] gnt,
    output logic [PIN_W-1:0]    idx,
    output logic                any
);

    always_comb begin
        idx = '0;
        any = |req;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (req[i]) idx = PIN_W'(i);
        end
        gnt = '0;
        if (any) gnt[idx] = 1'b1;
    end

endmodule

// File: rtl/pinsvc_engine.sv
module pinsvc_engine
    import pinsvc_pkg::*;
#(
    parameter int NUM_PINS     = 24,
    parameter int VEC_W        = 8,
    parameter int DEST_W       = 8,
    parameter int TGT_W        = 8,
    parameter int STORM_LIMIT  = 10000,
    parameter int DEFER_CYCLES = 100000,
    localparam int PIN_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_PINS-1:0]          pin_line,
    input  logic [NUM_PINS-1:0]          cfg_mask,
    input  logic [NUM_PINS-1:0]          cfg_level,
    input  logic [NUM_PINS-1:0]          cfg_logical,
    input  logic [DMODE_W*NUM_PINS-1:0]  cfg_dmode,
    input  logic [VEC_W*NUM_PINS-1:0]    cfg_vector,
    input  logic [DEST_W*NUM_PINS-1:0]   cfg_dest,
    input  logic [NUM_PINS-1:0]          cfg_rewrite,
    input  logic                         eoi_valid,
    input  logic [VEC_W-1:0]             eoi_vector,
    input  logic                         eoi_level,
    input  logic                         eoi_directed,
    output logic                         dlv_valid,
    output logic [PIN_W-1:0]             dlv_pin,
    output logic [VEC_W-1:0]             dlv_vector,
    output logic [DEST_W-1:0]            dlv_dest,
    output logic [DMODE_W-1:0]           dlv_dmode,
    output logic                         dlv_logical,
    output logic                         dlv_level,
    input  logic                         dlv_accept,
    input  logic [TGT_W-1:0]             dlv_count,
    output logic [NUM_PINS-1:0]          irr,
    output logic [NUM_PINS-1:0]          rirr
);

    svc_state_e state_q, state_d;

    logic [NUM_PINS-1:0] pend, storm, grant, accept_set, pick_gnt;
    logic [PIN_W-1:0]    pick_idx;
    logic                pick_any, refuse, take, defer_fire;

    // per-pin request / remote-IRR / storm counter
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        pinsvc_pin #(
            .VEC_W       (VEC_W),
            .STORM_LIMIT (STORM_LIMIT)
        ) u_pin (
            .clk          (clk),
            .rst_n        (rst_n),
            .line         (pin_line[g]),
            .is_level     (cfg_level[g]),
            .masked       (cfg_mask[g]),
            .vector       (cfg_vector[g*VEC_W +: VEC_W]),
            .eoi_valid    (eoi_valid),
            .eoi_vector   (eoi_vector),
            .eoi_level    (eoi_level),
            .eoi_directed (eoi_directed),
            .rewrite      (cfg_rewrite[g]),
            .defer_fire   (defer_fire),
            .grant        (grant[g]),
            .accept_set   (accept_set[g]),
            .irr          (irr[g]),
            .rirr         (rirr[g]),
            .pend         (pend[g]),
            .storm        (storm[g])
        );
    end

    pinsvc_defer #(
        .DEFER_CYCLES (DEFER_CYCLES)
    ) u_defer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (|storm),
        .fire  (defer_fire)
    );

    pinsvc_pick #(
        .NUM_PINS (NUM_PINS),
        .PIN_W    (PIN_W)
    ) u_pick (
        .req (pend),
        .gnt (pick_gnt),
        .idx (pick_idx),
        .any (pick_any)
    );

    assign refuse = cfg_mask[pick_idx] | (cfg_level[pick_idx] & rirr[pick_idx]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SVC_IDLE;
        else        state_q <= state_d;
    end

    // next state and strobes
    always_comb begin
        state_d    = state_q;
        grant      = '0;
        take       = 1'b0;
        accept_set = '0;
        unique case (state_q)
            SVC_IDLE: begin
                if (pick_any) begin
                    grant = pick_gnt;
                    if (!refuse) begin
                        take    = 1'b1;
                        state_d = SVC_OFFER;
                    end
                end
            end
            SVC_OFFER: begin
                if (dlv_accept) begin
                    state_d = SVC_IDLE;
                    if (dlv_level && (dlv_count != '0))
                        accept_set[dlv_pin] = 1'b1;
                end
            end
            default: state_d = SVC_IDLE;
        endcase
    end

    // request field holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dlv_pin     <= '0;
            dlv_vector  <= '0;
            dlv_dest    <= '0;
            dlv_dmode   <= '0;
            dlv_logical <= 1'b0;
            dlv_level   <= 1'b0;
        end else if (take) begin
            dlv_pin     <= pick_idx;
            dlv_vector  <= cfg_vector[int'(pick_idx)*VEC_W +: VEC_W];
            dlv_dest    <= cfg_dest[int'(pick_idx)*DEST_W +: DEST_W];
            dlv_dmode   <= cfg_dmode[int'(pick_idx)*DMODE_W +: DMODE_W];
            dlv_logical <= cfg_logical[pick_idx];
            dlv_level   <= cfg_level[pick_idx];
        end
    end

    assign dlv_valid = (state_q == SVC_OFFER);

endmodule

// File: rtl/pinsvc_engine_checker.sv
module pinsvc_engine_checker #(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = 5,
    parameter int VEC_W    = 8,
    parameter int DEST_W   = 8,
    parameter int TGT_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] cfg_mask,
    input logic [NUM_PINS-1:0] cfg_level,
    input logic [NUM_PINS-1:0] cfg_rewrite,
    input logic                eoi_valid,
    input logic                eoi_level,
    input logic                eoi_directed,
    input logic                dlv_valid,
    input logic                dlv_accept,
    input logic [PIN_W-1:0]    dlv_pin,
    input logic [VEC_W-1:0]    dlv_vector,
    input logic [DEST_W-1:0]   dlv_dest,
    input logic                dlv_level,
    input logic [TGT_W-1:0]    dlv_count,
    input logic [NUM_PINS-1:0] rirr,
    input logic [NUM_PINS-1:0] pend,
    input logic [NUM_PINS-1:0] grant
);

    logic [NUM_PINS-1:0] mask_q, level_q, rirr_q;
    logic [PIN_W-1:0]    pin_q;

    always_ff @(posedge clk) begin
        mask_q  <= cfg_mask;
        level_q <= cfg_level;
        rirr_q  <= rirr;
        pin_q   <= dlv_pin;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!dlv_valid && (rirr == '0)));

    a_r3_no_refused_offer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dlv_valid) |-> (!mask_q[dlv_pin] && !(level_q[dlv_pin] && rirr_q[dlv_pin])));

    a_r4_hold_until_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_accept) |=>
            (dlv_valid && $stable(dlv_pin) && $stable(dlv_vector) && $stable(dlv_dest)));

    a_r5_accept_sets_rirr: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_accept && dlv_level && (dlv_count != '0)) |=> rirr[pin_q]);

    a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (((grant & pend) == grant) && (((grant - 1'b1) & pend) == '0)));

    a_r8_directed_keeps_rirr: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && (eoi_directed || !eoi_level) && !(dlv_valid && dlv_accept)
         && (cfg_rewrite == '0)) |=> (rirr == $past(rirr)));

endmodule

bind pinsvc_engine pinsvc_engine_checker #(
    .NUM_PINS (NUM_PINS),
    .PIN_W    (PIN_W),
    .VEC_W    (VEC_W),
    .DEST_W   (DEST_W),
    .TGT_W    (TGT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mask     (cfg_mask),
    .cfg_level    (cfg_level),
    .cfg_rewrite  (cfg_rewrite),
    .eoi_valid    (eoi_valid),
    .eoi_level    (eoi_level),
    .eoi_directed (eoi_directed),
    .dlv_valid    (dlv_valid),
    .dlv_accept   (dlv_accept),
    .dlv_pin      (dlv_pin),
    .dlv_vector   (dlv_vector),
    .dlv_dest     (dlv_dest),
    .dlv_level    (dlv_level),
    .dlv_count    (dlv_count),
    .rirr         (rirr),
    .pend         (pend),
    .grant        (grant)
);

// File: tb/pinsvc_engine_bench.sv
module pinsvc_engine_bench;

    localparam int NP    = 4;
    localparam int PW    = 2;
    localparam int LIMIT = 4;
    localparam int DEFER = 40;

    typedef struct packed {
        logic [PW-1:0] pin;
        logic [7:0]    vec;
        logic [7:0]    dest;
        logic [2:0]    dm;
        logic          lg;
        logic          lvl;
        logic [3:0]    cnt;
        logic [3:0]    hold;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] line_c = '0, msk_c = '0, lvl_c = 4'b0110, lg_c = 4'b1010, rw_c = '0;
    logic [7:0]    vec_c [NP];
    logic [7:0]    dest_c[NP];
    logic [2:0]    dm_c  [NP];
    logic [3*NP-1:0] cfg_dmode;
    logic [8*NP-1:0] cfg_vector, cfg_dest;
    logic          eoi_valid = 1'b0, eoi_level = 1'b0, eoi_directed = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic          acc_r = 1'b0;
    logic [3:0]    cnt_r = '0;

    logic          dlv_valid, dlv_logical, dlv_level;
    logic [PW-1:0] dlv_pin;
    logic [7:0]    dlv_vector, dlv_dest;
    logic [2:0]    dlv_dmode;
    logic [NP-1:0] irr, rirr;

    int   n_vec = 0, n_bad = 0;
    bit   done = 0;
    exp_t q[$];
    exp_t cur;
    bit   busy = 0;
    int   wait_n = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            cfg_dmode[i*3 +: 3]  = dm_c[i];
            cfg_vector[i*8 +: 8] = vec_c[i];
            cfg_dest[i*8 +: 8]   = dest_c[i];
        end
    end

    pinsvc_engine #(
        .NUM_PINS(NP), .VEC_W(8), .DEST_W(8), .TGT_W(4),
        .STORM_LIMIT(LIMIT), .DEFER_CYCLES(DEFER)
    ) u_pinsvc_engine (
        .clk(clk), .rst_n(rst_n), .pin_line(line_c), .cfg_mask(msk_c),
        .cfg_level(lvl_c), .cfg_logical(lg_c), .cfg_dmode(cfg_dmode),
        .cfg_vector(cfg_vector), .cfg_dest(cfg_dest), .cfg_rewrite(rw_c),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
        .eoi_directed(eoi_directed), .dlv_valid(dlv_valid), .dlv_pin(dlv_pin),
        .dlv_vector(dlv_vector), .dlv_dest(dlv_dest), .dlv_dmode(dlv_dmode),
        .dlv_logical(dlv_logical), .dlv_level(dlv_level), .dlv_accept(acc_r),
        .dlv_count(cnt_r), .irr(irr), .rirr(rirr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // driver side: record the delivery the requirements predict
    task automatic expect_dlv(input int pin, input int cnt, input int hold);
        exp_t e;
        e.pin = PW'(pin); e.vec = vec_c[pin]; e.dest = dest_c[pin]; e.dm = dm_c[pin];
        e.lg = lg_c[pin]; e.lvl = lvl_c[pin]; e.cnt = 4'(cnt); e.hold = 4'(hold);
        q.push_back(e);
    endtask

    // monitor: pop and compare each offered request
    always @(negedge clk) begin
        if (!rst_n) begin
            acc_r = 1'b0; busy = 0;
        end else if (acc_r) begin
            acc_r = 1'b0;
        end else if (dlv_valid) begin
            if (!busy) begin
                if (q.size() == 0) begin
                    chk(0, "R3", "unexpected request on pin", int'(dlv_pin), -1);
                    cur = '0; cur.cnt = 4'd1;
                end else begin
                    cur = q.pop_front();
                    chk(dlv_pin == cur.pin, "R6", "served pin", int'(dlv_pin), int'(cur.pin));
                    chk(dlv_vector == cur.vec, "R4", "vector", int'(dlv_vector), int'(cur.vec));
                    chk(dlv_dest == cur.dest, "R4", "dest", int'(dlv_dest), int'(cur.dest));
                    chk(dlv_dmode == cur.dm, "R4", "dmode", int'(dlv_dmode), int'(cur.dm));
                    chk(dlv_logical == cur.lg, "R4", "logical", int'(dlv_logical), int'(cur.lg));
                    chk(dlv_level == cur.lvl, "R4", "level", int'(dlv_level), int'(cur.lvl));
                end
                busy = 1; wait_n = int'(cur.hold);
            end else begin
                chk(dlv_vector == cur.vec && dlv_pin == cur.pin, "R4", "held vector",
                    int'(dlv_vector), int'(cur.vec));
            end
            if (wait_n == 0) begin
                acc_r = 1'b1; cnt_r = cur.cnt; busy = 0;
            end else begin
                wait_n--;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_line(input int pin, input bit v);
        @(negedge clk); line_c[pin] = v;
    endtask

    task automatic eoi(input logic [7:0] v, input bit lvl, input bit dir);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v; eoi_level = lvl; eoi_directed = dir;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic rewrite(input int pin);
        @(negedge clk); rw_c[pin] = 1'b1;
        @(negedge clk); rw_c = '0;
    endtask

    task automatic drained(input string req);
        tick(8);
        chk(q.size() == 0, req, "outstanding expected requests", q.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; line_c = '0;
        tick(2); rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL R1 watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        vec_c  = '{8'h30, 8'h41, 8'h52, 8'h63};
        dest_c = '{8'h01, 8'h12, 8'h24, 8'h48};
        dm_c   = '{3'd0, 3'd1, 3'd0, 3'd2};
        tick(3);
        // R1 reset state
        chk(dlv_valid == 0, "R1", "valid in reset", int'(dlv_valid), 0);
        rst_n = 1'b1;
        tick(2);
        chk(irr == 0 && rirr == 0, "R1", "irr/rirr after reset", int'({irr, rirr}), 0);

        // R2 edge pin, held request (R4), then held line coalesced
        expect_dlv(0, 1, 3);
        set_line(0, 1);
        drained("R2");
        chk(rirr[0] == 0, "R5", "edge rirr", int'(rirr[0]), 0);
        tick(10);
        chk(irr[0] == 1, "R2", "irr held edge line", int'(irr[0]), 1);
        set_line(0, 0);
        tick(2);
        chk(irr[0] == 0, "R2", "irr after drop", int'(irr[0]), 0);

        // R6 two pins at once, lowest first
        expect_dlv(0, 1, 0);
        expect_dlv(3, 1, 0);
        @(negedge clk); line_c[3] = 1; line_c[0] = 1;
        drained("R6");
        @(negedge clk); line_c[3] = 0; line_c[0] = 0;

        // R5 level pin, zero and nonzero target counts
        expect_dlv(1, 0, 0);
        set_line(1, 1);
        drained("R5");
        chk(rirr[1] == 0, "R5", "rirr after zero count", int'(rirr[1]), 0);
        expect_dlv(2, 2, 0);
        set_line(2, 1);
        drained("R5");
        chk(rirr[2] == 1, "R5", "rirr after accept", int'(rirr[2]), 1);

        // R3 level with remote IRR set: rewrite attempt refused
        rewrite(2);
        drained("R3");
        // R8 directed and edge-mode EOIs leave remote IRR alone
        eoi(8'h52, 1, 1);
        drained("R8");
        chk(rirr[2] == 1, "R8", "rirr after directed EOI", int'(rirr[2]), 1);
        eoi(8'h52, 0, 0);
        drained("R8");
        chk(rirr[2] == 1, "R8", "rirr after edge EOI", int'(rirr[2]), 1);

        // R3 masked pin is not offered
        msk_c[3] = 1;
        set_line(3, 1);
        drained("R3");
        chk(irr[3] == 1, "R3", "masked irr", int'(irr[3]), 1);
        set_line(3, 0);
        msk_c[3] = 0;

        // R7 shared vector: both pins redelivered, lowest first
        vec_c[1] = 8'h52;
        expect_dlv(1, 0, 0);
        expect_dlv(2, 1, 0);
        eoi(8'h52, 1, 0);
        drained("R7");
        chk(rirr[2] == 1, "R7", "rirr after redelivery", int'(rirr[2]), 1);
        vec_c[1] = 8'h41;

        // R2 level line falls: EOI clears remote IRR, nothing delivered
        set_line(2, 0);
        tick(2);
        chk(irr[2] == 0, "R2", "level irr after drop", int'(irr[2]), 0);
        eoi(8'h52, 1, 0);
        drained("R2");
        chk(rirr[2] == 0, "R7", "rirr after EOI", int'(rirr[2]), 0);

        // R11 edge rewrite clears remote IRR, level rewrite services
        expect_dlv(2, 1, 0);
        set_line(2, 1);
        drained("R11");
        lvl_c[2] = 0;
        rewrite(2);
        tick(2);
        chk(rirr[2] == 0, "R11", "rirr after edge rewrite", int'(rirr[2]), 0);
        lvl_c[2] = 1;
        expect_dlv(2, 1, 0);
        rewrite(2);
        drained("R11");
        chk(rirr[2] == 1, "R11", "rirr after level rewrite", int'(rirr[2]), 1);

        // R12 accept and EOI in the same cycle
        do_reset();
        expect_dlv(2, 1, 0);
        @(negedge clk); line_c[2] = 1;
        @(negedge clk);
        @(negedge clk);
        eoi_valid = 1; eoi_vector = 8'h52; eoi_level = 1; eoi_directed = 0;
        @(negedge clk); eoi_valid = 0;
        drained("R12");
        chk(rirr[2] == 1, "R12", "rirr after overlap", int'(rirr[2]), 1);

        // R9 / R10 storm and deferral
        do_reset();
        expect_dlv(1, 0, 0);
        expect_dlv(2, 1, 0);
        @(negedge clk); line_c[1] = 1; line_c[2] = 1;
        drained("R9");
        for (int k = 1; k < LIMIT; k++) begin
            expect_dlv(2, 1, 0);
            eoi(8'h52, 1, 0);
            drained("R9");
        end
        eoi(8'h52, 1, 0);
        tick(DEFER - 3);
        chk(rirr[2] == 0, "R9", "rirr while deferred", int'(rirr[2]), 0);
        expect_dlv(1, 0, 0);
        expect_dlv(2, 1, 0);
        tick(12);
        chk(q.size() == 0, "R10", "deferred requests outstanding", q.size(), 0);
        // counter cleared by storm: next EOI redelivers at once
        expect_dlv(2, 1, 0);
        eoi(8'h52, 1, 0);
        drained("R9");
        // masked EOI resets counter
        msk_c[2] = 1;
        eoi(8'h52, 1, 0);
        drained("R9");
        chk(rirr[2] == 0, "R9", "rirr after masked EOI", int'(rirr[2]), 0);
        msk_c[2] = 0;
        expect_dlv(2, 1, 0);
        rewrite(2);
        drained("R11");
        for (int k = 1; k < LIMIT; k++) begin
            expect_dlv(2, 1, 0);
            eoi(8'h52, 1, 0);
            drained("R9");
        end

        done = 1;
        finish_run();
    end

endmodule